// File: doc/BRIEF.md
# Compressed Elapsed Cycle Counter

This block measures how many active cycles pass between two recorded control transfers and hands each new record a compact 16-bit timing field. A free-running internal counter advances once per clock while the recording logic is active, that is, while the current mode is enabled and recording is not frozen. When a record strobe arrives, the current count is packed into a 4-bit exponent and a 12-bit mantissa. That field goes out together with a validity flag, and the counter starts again from zero.

The packed form works like a small floating-point number. Counts under 4096 go out unchanged with a zero exponent. Larger counts keep only their twelve most significant bits below an implied leading one. The validity flag tells software whether the interval is trustworthy. It is low for the first record after the counter was reset by a control-register write or a clear command, and high otherwise. The number of implemented exponent bits is a parameter, and it alone sets the width of the internal counter.

Top module: `elapsed_cycle_counter`

## Requirements
- R1: The internal count increases by one on each clock edge where `active_i` is 1 and no record, clear or control write is present. With `active_i` at 0 the count holds.
- R2: A `clear_i` or `ctl_wr_i` pulse sets the count to zero, and the next record carries `cc_valid_o` = 0.
- R3: On a `record_i` pulse the outputs show the count reached before that edge, from the clock edge that takes the pulse onward. They hold that value until the next record, and the count restarts from zero.
- R4: A count below 4096 is output with `cc_exp_o` = 0 and `cc_mant_o` equal to the count.
- R5: A count of 4096 or more with its leading one at bit L is output with `cc_exp_o` = L-11 and `cc_mant_o` = count bits L-1 down to L-12. The lower bits are dropped, so the decoded value is (4096 + mantissa) << (exponent-1).
- R6: The count stops at its all-ones maximum instead of wrapping, so the output saturates at all ones in every implemented bit.
- R7: With EXP_BITS implemented exponent bits, the counter is 11 + 2^EXP_BITS bits wide, and `cc_exp_o` bits at and above EXP_BITS always read 0.
- R8: A record with no clear or control write since the previous record carries `cc_valid_o` = 1. The first record after reset carries 0.
- R9: When a clear or control write falls in the same cycle as a record, the record still captures the count and flag from before that cycle, and the following record carries `cc_valid_o` = 0.
- R10: After reset, all outputs read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| active_i | input | 1 | Recording active this cycle (mode enabled, not frozen) |
| record_i | input | 1 | A transfer is being recorded this cycle |
| ctl_wr_i | input | 1 | Control register written this cycle |
| clear_i | input | 1 | Clear command this cycle |
| cc_exp_o | output | 4 | Exponent of the captured count |
| cc_mant_o | output | 12 | Mantissa of the captured count |
| cc_valid_o | output | 1 | Captured count is valid |

## Verification
The packing is tried with counts of 5, 4095, 4096, 5000 and 9000. These separate the raw path from the shifted path, show the boundary where the exponent first turns non-zero, and show which low bits are dropped once the leading one moves up. A broken run of active cycles shows that idle cycles are not counted. A record with no cycles in between shows that the counter restarts. Clear and control-write pulses are placed both between records and in the same cycle as a record, which separates the count reset from the flag behaviour. A run long enough to pass the counter's maximum, built with two exponent bits, shows both saturation and that the upper exponent bits read as zero.

// File: rtl/ecc_pkg.sv
// Package: shared sizing helper and the packed count type for the
// elapsed cycle counter. Assumes exponent widths of 0 to 4 bits.
package ecc_pkg;

    localparam int MANT_W = 12;
    localparam int EXP_W  = 4;

    // Counter width for a given number of implemented exponent bits.
    function automatic int cnt_width(input int exp_bits);
        return 11 + (1 << exp_bits);
    endfunction

    typedef struct packed {
        logic [EXP_W-1:0]  expo;
        logic [MANT_W-1:0] mant;
    } cc_field_t;

endpackage

// File: rtl/ecc_counter.sv
// Saturating active-cycle counter with its validity flag.
// Assumes the strobes are single-cycle and synchronous to clk.
// A clear or control write beats a record, and both beat counting.
module ecc_counter #(
    parameter int CNT_W = 27
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic             record_i,
    input  logic             reset_cnt_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             seen_o
);

    logic at_max;

    // Detect the all-ones saturation point.
    always_comb at_max = &cnt_o;

    // Advance, restart or zero the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (reset_cnt_i || record_i) begin
            cnt_o <= '0;
        end else if (active_i && !at_max) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end

    // Track whether the interval since the last record is unbroken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_o <= 1'b0;
        end else if (reset_cnt_i) begin
            seen_o <= 1'b0;
        end else if (record_i) begin
            seen_o <= 1'b1;
        end
    end

endmodule

// File: rtl/ecc_encoder.sv
// Combinational packer: count to exponent and 12-bit mantissa with an
// implied leading one. Assumes CNT_W = 11 + 2**EXP_BITS, so every count
// fits the implemented exponent range and no overflow path is needed.
module ecc_encoder
    import ecc_pkg::*;
#(
    parameter int CNT_W = 27
) (
    input  logic [CNT_W-1:0] cnt_i,
    output cc_field_t        field_o
);

    // Find the highest set bit at or above 12 and take the bits below it.
    always_comb begin
        field_o.expo = '0;
        field_o.mant = cnt_i[MANT_W-1:0];
        for (int i = MANT_W; i < CNT_W; i++) begin
            if (cnt_i[i]) begin
                field_o.expo = EXP_W'(i - 11);
                field_o.mant = cnt_i[i-1 -: MANT_W];
            end
        end
    end

endmodule

// File: rtl/ecc_capture.sv
// Output register: holds the packed count and flag of the last record.
// Assumes record_i is a single-cycle strobe.
module ecc_capture
    import ecc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      record_i,
    input  cc_field_t field_i,
    input  logic      valid_i,
    output cc_field_t field_o,
    output logic      valid_o
);

    // Load the packed field and flag on each record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            field_o <= '0;
            valid_o <= 1'b0;
        end else if (record_i) begin
            field_o <= field_i;
            valid_o <= valid_i;
        end
    end

endmodule

// File: rtl/elapsed_cycle_counter.sv
// Top: counts active cycles between records and presents the packed
// 16-bit field with a validity flag. EXP_BITS (0..4) sets how many
// exponent bits exist, and from that the internal counter width.
module elapsed_cycle_counter
    import ecc_pkg::*;
#(
    parameter int EXP_BITS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        active_i,
    input  logic        record_i,
    input  logic        ctl_wr_i,
    input  logic        clear_i,
    output logic [3:0]  cc_exp_o,
    output logic [11:0] cc_mant_o,
    output logic        cc_valid_o
);

    localparam int CNT_W = cnt_width(EXP_BITS);

    logic [CNT_W-1:0] cnt_q;
    logic             seen_q;
    logic             reset_cnt;
    cc_field_t        packed_now;
    cc_field_t        packed_q;

    // Either software action restarts the interval.
    always_comb reset_cnt = clear_i | ctl_wr_i;

    ecc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .active_i    (active_i),
        .record_i    (record_i),
        .reset_cnt_i (reset_cnt),
        .cnt_o       (cnt_q),
        .seen_o      (seen_q)
    );

    ecc_encoder #(.CNT_W(CNT_W)) u_enc (
        .cnt_i   (cnt_q),
        .field_o (packed_now)
    );

    ecc_capture u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .record_i (record_i),
        .field_i  (packed_now),
        .valid_i  (seen_q),
        .field_o  (packed_q),
        .valid_o  (cc_valid_o)
    );

    // Drive the output ports from the captured field.
    always_comb begin
        cc_exp_o  = packed_q.expo;
        cc_mant_o = packed_q.mant;
    end

endmodule

// File: rtl/ecc_checker.sv
// Checker bound to the top: temporal properties of the counter and the
// captured outputs. Assumes the same EXP_BITS as the bound instance.
module ecc_checker #(
    parameter int EXP_BITS = 4,
    parameter int CNT_W    = 27
) (
    input logic             clk,
    input logic             rst_n,
    input logic             active_i,
    input logic             record_i,
    input logic             ctl_wr_i,
    input logic             clear_i,
    input logic [3:0]       cc_exp_o,
    input logic [11:0]      cc_mant_o,
    input logic             cc_valid_o,
    input logic [CNT_W-1:0] cnt_q,
    input logic             seen_q
);

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_i && !record_i && !clear_i && !ctl_wr_i) |=> $stable(cnt_q)); // R1

    AST_ACTIVE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && !record_i && !clear_i && !ctl_wr_i && !(&cnt_q)) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R1

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i || ctl_wr_i) |=> (cnt_q == '0 && !seen_q)); // R2

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !record_i |=> ($stable(cc_exp_o) && $stable(cc_mant_o) && $stable(cc_valid_o))); // R3

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ((&cnt_q) && !record_i && !clear_i && !ctl_wr_i) |=> (&cnt_q)); // R6

    AST_EXP_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_exp_o >> EXP_BITS) == 4'd0); // R7

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (record_i && !clear_i && !ctl_wr_i) |=> seen_q); // R8

    AST_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (record_i && (clear_i || ctl_wr_i)) |=> (cc_valid_o == $past(seen_q) && !seen_q)); // R9

endmodule

bind elapsed_cycle_counter ecc_checker #(
    .EXP_BITS (EXP_BITS),
    .CNT_W    (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .active_i   (active_i),
    .record_i   (record_i),
    .ctl_wr_i   (ctl_wr_i),
    .clear_i    (clear_i),
    .cc_exp_o   (cc_exp_o),
    .cc_mant_o  (cc_mant_o),
    .cc_valid_o (cc_valid_o),
    .cnt_q      (cnt_q),
    .seen_q     (seen_q)
);

// File: tb/sim_elapsed_cycle_counter.sv
// Directed bench: one task per scenario, each checking its own results.
// Built with two exponent bits so that saturation (32767) is reachable.
module sim_elapsed_cycle_counter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        active_i = 1'b0;
    logic        record_i = 1'b0;
    logic        ctl_wr_i = 1'b0;
    logic        clear_i = 1'b0;
    logic [3:0]  cc_exp_o;
    logic [11:0] cc_mant_o;
    logic        cc_valid_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    elapsed_cycle_counter #(.EXP_BITS(2)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .active_i   (active_i),
        .record_i   (record_i),
        .ctl_wr_i   (ctl_wr_i),
        .clear_i    (clear_i),
        .cc_exp_o   (cc_exp_o),
        .cc_mant_o  (cc_mant_o),
        .cc_valid_o (cc_valid_o)
    );

    task automatic expect_out(input logic [3:0] e, input logic [11:0] m,
                              input logic v, input string tag);
        checks++;
        if (cc_exp_o !== e || cc_mant_o !== m || cc_valid_o !== v) begin
            failures++;
            $display("FAIL %s: got exp=%0d mant=%0d valid=%0b, expected exp=%0d mant=%0d valid=%0b",
                     tag, cc_exp_o, cc_mant_o, cc_valid_o, e, m, v);
        end
    endtask

    task automatic run_active(input int n);
        active_i = 1'b1;
        repeat (n) @(negedge clk);
        active_i = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_record();
        record_i = 1'b1;
        @(negedge clk);
        record_i = 1'b0;
    endtask

    task automatic pulse_clear();
        clear_i = 1'b1;
        @(negedge clk);
        clear_i = 1'b0;
    endtask

    task automatic pulse_wr();
        ctl_wr_i = 1'b1;
        @(negedge clk);
        ctl_wr_i = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        expect_out(4'd0, 12'd0, 1'b0, "R10 reset state");
    endtask

    task automatic t_small();
        run_active(5);
        pulse_record();
        expect_out(4'd0, 12'd5, 1'b0, "R4 R8 count 5, first record after reset");
        run_active(4095);
        pulse_record();
        expect_out(4'd0, 12'hFFF, 1'b1, "R4 count 4095");
    endtask

    task automatic t_large();
        run_active(4096);
        pulse_record();
        expect_out(4'd1, 12'd0, 1'b1, "R5 count 4096");
        run_active(5000);
        pulse_record();
        expect_out(4'd1, 12'd904, 1'b1, "R5 count 5000");
        run_active(9000);
        pulse_record();
        expect_out(4'd2, 12'd404, 1'b1, "R5 count 9000 drops low bit");
    endtask

    task automatic t_gating();
        run_active(10);
        idle(10);
        run_active(5);
        idle(3);
        pulse_record();
        expect_out(4'd0, 12'd15, 1'b1, "R1 only active cycles counted");
    endtask

    task automatic t_hold_restart();
        run_active(30);
        idle(20);
        expect_out(4'd0, 12'd15, 1'b1, "R3 outputs hold between records");
        pulse_record();
        expect_out(4'd0, 12'd30, 1'b1, "R3 capture after hold");
        pulse_record();
        expect_out(4'd0, 12'd0, 1'b1, "R3 counter restarts after record");
    endtask

    task automatic t_clear();
        run_active(100);
        pulse_clear();
        run_active(7);
        pulse_record();
        expect_out(4'd0, 12'd7, 1'b0, "R2 clear zeroes count and flag");
        run_active(3);
        pulse_record();
        expect_out(4'd0, 12'd3, 1'b1, "R8 flag returns after clean interval");
    endtask

    task automatic t_ctl_write();
        run_active(50);
        pulse_wr();
        run_active(9);
        pulse_record();
        expect_out(4'd0, 12'd9, 1'b0, "R2 control write zeroes count and flag");
    endtask

    task automatic t_same_cycle();
        pulse_record();
        run_active(20);
        record_i = 1'b1;
        clear_i = 1'b1;
        @(negedge clk);
        record_i = 1'b0;
        clear_i = 1'b0;
        expect_out(4'd0, 12'd20, 1'b1, "R9 record with clear keeps prior value");
        run_active(2);
        pulse_record();
        expect_out(4'd0, 12'd2, 1'b0, "R9 next record invalid");
    endtask

    task automatic t_saturate();
        run_active(33000);
        pulse_record();
        expect_out(4'd3, 12'hFFF, 1'b1, "R6 R7 saturation at all ones, top exponent bits zero");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_small();
        t_large();
        t_gating();
        t_hold_restart();
        t_clear();
        t_ctl_write();
        t_same_cycle();
        t_saturate();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule